// File: doc/BRIEF.md
# Composite Sync Conditioning Processor

This block cleans up a one-bit horizontal or composite sync signal that is sampled by a fast system clock, and prepares it for a downstream line-locked PLL. It works out whether the sync pulses are active-high or active-low by integrating the raw level over a fixed sample window. It then flips the signal as needed, so that everything after that point sees positive-going pulses. It also emits one clean horizontal reference per line, with a single-cycle strobe on each accepted leading edge.

Each leading edge that is accepted opens a blanking window of three quarters of the last measured line period. The half-line equalizing pulses fall inside this window and never reach the phase comparator. The block measures the duty cycle of every line. When two lines in a row exceed a set fraction, it raises a vertical-sync flag. A PLL-inhibit output covers the whole vertical interval, and an external request can also force it on.

Top module: `sync_conditioner`

## Requirements
- R1: `polarity` (1 = active-high pulses) resets to 1. At the end of each window of 2^WIN_LOG2 samples, the window's verdict is 1 when the count of high samples is at most half the window, and 0 otherwise. `polarity` takes the new verdict only when it equals the verdict of the previous window, so it cannot change within 600 cycles of an input polarity reversal.
- R2: A leading edge of the normalised pulse that is accepted gives one `hsync_strobe` pulse one cycle wide. The strobe is high two clock edges after the edge is present on `sync_in`, so a stream of lines gives exactly one strobe per line.
- R3: `hsync_out` goes high together with the strobe. It stays high for as long as the normalised pulse lasts, so its high time per line equals the pulse width.
- R4: A sync pulse that lasts only one sample is still accepted as a line reference.
- R5: After an accepted edge, further leading edges are ignored until three quarters of the last measured line period have passed. Half-line equalizing pulses therefore produce neither a strobe nor any `hsync_out` high time.
- R6: A line counts as "wide" when active_samples*256 > period*THRESH_Q8 (the default threshold is 25%). `vsync` sets once two consecutive lines are wide and clears once two consecutive lines are not wide. A single wide line changes nothing.
- R7: `pll_inhibit` is `vsync` OR `inhibit_req`, with no cycle of delay from `inhibit_req`, and it applies in reset as well.
- R8: While reset is held, `hsync_out`, `hsync_strobe` and `vsync` are 0 and `polarity` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset |
| sync_in | input | 1 | Raw horizontal or composite sync level |
| inhibit_req | input | 1 | External request to hold the PLL inhibited |
| hsync_out | output | 1 | Clean, positive horizontal sync pulse |
| hsync_strobe | output | 1 | One-cycle mark of each accepted leading edge |
| polarity | output | 1 | Detected input polarity, 1 = active-high |
| vsync | output | 1 | Extracted vertical sync flag |
| pll_inhibit | output | 1 | Hold signal for the downstream PLL |

## Verification
The line path is exercised with several input patterns:
- Normal 10% lines check strobe count, pulse width and edge latency.
- One-sample pulses check that the narrowest input is accepted.
- Lines carrying half-line equalizing pulses separate a working blanking window from one that lets the extra pulse through, because the `hsync_out` high time doubles in that case.
- A lone 35% line followed by normal lines, set against a run of three 35% lines, separates the one-line hysteresis from an instant duty decision.
- The clearing side of the hysteresis is timed in the same run.

An inverted input stream is checked twice: once early, to show that a single window cannot flip the polarity, and once late, to show that the flip happens and that edges and widths then match the positive case.

// File: rtl/sync_cond_pkg.sv
package sync_cond_pkg;

  // Earliest elapsed count at which a new leading edge may be accepted.
  function automatic logic [31:0] blank_limit(input logic [31:0] period);
    return period - (period >> 2);
  endfunction

  // Line duty above threshold (threshold in 1/256 units).
  function automatic logic duty_over(input logic [31:0] active,
                                     input logic [31:0] period,
                                     input logic [31:0] thr_q8);
    return (active << 8) > (period * thr_q8);
  endfunction

  // True when high samples are the minority (or tie) over the window.
  function automatic logic high_is_minority(input logic [31:0] highs,
                                            input logic [31:0] win_len);
    return (highs << 1) <= win_len;
  endfunction

endpackage

// File: rtl/polarity_detect.sv
module polarity_detect #(
  parameter int WIN_LOG2 = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp,
  output logic polarity,
  output logic win_end
);
  localparam int WIN_LEN = 1 << WIN_LOG2;

  logic [WIN_LOG2-1:0] win_cnt;
  logic [WIN_LOG2:0]   hi_cnt;
  logic [WIN_LOG2:0]   hi_total;
  logic                verdict;
  logic                prev_verdict;

  assign win_end  = &win_cnt;
  assign hi_total = hi_cnt + {{WIN_LOG2{1'b0}}, smp};
  assign verdict  = sync_cond_pkg::high_is_minority(32'(hi_total), 32'(WIN_LEN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt      <= '0;
      hi_cnt       <= '0;
      prev_verdict <= 1'b1;
      polarity     <= 1'b1;
    end else begin
      win_cnt <= win_cnt + 1'b1;
      if (win_end) begin
        hi_cnt       <= '0;
        prev_verdict <= verdict;
        if (verdict == prev_verdict) polarity <= verdict;
      end else begin
        hi_cnt <= hi_total;
      end
    end
  end

  // R1: polarity moves only on a window boundary
  assert_pol_window_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (polarity != $past(polarity)) |-> $past(win_end));

endmodule

// File: rtl/line_gate.sv
module line_gate #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             norm,
  output logic             accept,
  output logic             line_done,
  output logic [CNT_W-1:0] line_period,
  output logic [CNT_W-1:0] line_active
);
  logic             norm_q;
  logic             rise;
  logic             have_edge;
  logic [CNT_W-1:0] period_cnt;
  logic [CNT_W-1:0] active_cnt;
  logic [CNT_W-1:0] period_meas;
  logic [CNT_W-1:0] elapsed;
  logic [CNT_W-1:0] limit;

  assign rise        = norm & ~norm_q;
  assign elapsed     = (&period_cnt) ? period_cnt : period_cnt + 1'b1;
  assign limit       = CNT_W'(sync_cond_pkg::blank_limit(32'(period_meas)));
  assign accept      = rise && (elapsed >= limit);
  assign line_done   = accept && have_edge;
  assign line_period = elapsed;
  assign line_active = active_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      norm_q      <= 1'b0;
      have_edge   <= 1'b0;
      period_cnt  <= '0;
      active_cnt  <= '0;
      period_meas <= '0;
    end else begin
      norm_q <= norm;
      if (accept) begin
        if (have_edge) period_meas <= elapsed;
        have_edge  <= 1'b1;
        period_cnt <= '0;
        active_cnt <= CNT_W'(1);
      end else begin
        period_cnt <= elapsed;
        if (norm && !(&active_cnt)) active_cnt <= active_cnt + 1'b1;
      end
    end
  end

  // R5: the blanking reference only changes on an accepted edge
  assert_period_on_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (period_meas != $past(period_meas)) |-> $past(accept));

endmodule

// File: rtl/vsync_detect.sv
module vsync_detect #(
  parameter int CNT_W     = 16,
  parameter int THRESH_Q8 = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_done,
  input  logic [CNT_W-1:0] line_period,
  input  logic [CNT_W-1:0] line_active,
  output logic             vsync
);
  logic over;
  logic over_prev;

  assign over = sync_cond_pkg::duty_over(32'(line_active), 32'(line_period),
                                         32'(THRESH_Q8));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      over_prev <= 1'b0;
      vsync     <= 1'b0;
    end else if (line_done) begin
      over_prev <= over;
      if (over && over_prev)        vsync <= 1'b1;
      else if (!over && !over_prev) vsync <= 1'b0;
    end
  end

  // R6: the vertical flag only moves when a line has been closed
  assert_vsync_on_line_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync != $past(vsync)) |-> $past(line_done));

endmodule

// File: rtl/sync_conditioner.sv
module sync_conditioner #(
  parameter int CNT_W     = 16,
  parameter int WIN_LOG2  = 9,
  parameter int THRESH_Q8 = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in,
  input  logic inhibit_req,
  output logic hsync_out,
  output logic hsync_strobe,
  output logic polarity,
  output logic vsync,
  output logic pll_inhibit
);
  logic             smp;
  logic             norm;
  logic             accept;
  logic             line_done;
  logic             win_end;
  logic [CNT_W-1:0] line_period;
  logic [CNT_W-1:0] line_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smp <= 1'b0;
    else        smp <= sync_in;
  end

  polarity_detect #(.WIN_LOG2(WIN_LOG2)) u_pol (
    .clk(clk), .rst_n(rst_n), .smp(smp), .polarity(polarity), .win_end(win_end)
  );

  assign norm = polarity ? smp : ~smp;

  line_gate #(.CNT_W(CNT_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .norm(norm), .accept(accept),
    .line_done(line_done), .line_period(line_period), .line_active(line_active)
  );

  vsync_detect #(.CNT_W(CNT_W), .THRESH_Q8(THRESH_Q8)) u_vs (
    .clk(clk), .rst_n(rst_n), .line_done(line_done),
    .line_period(line_period), .line_active(line_active), .vsync(vsync)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hsync_strobe <= 1'b0;
      hsync_out    <= 1'b0;
    end else begin
      hsync_strobe <= accept;
      if (accept)     hsync_out <= 1'b1;
      else if (!norm) hsync_out <= 1'b0;
    end
  end

  assign pll_inhibit = vsync | inhibit_req;

  // R2: every strobe coincides with a live output pulse
  assert_strobe_marks_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hsync_strobe |-> hsync_out);

  // R3: an output pulse never starts without an accepted edge
  assert_pulse_starts_on_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsync_out) |-> hsync_strobe);

endmodule

// File: tb/test_sync_conditioner.sv
module test_sync_conditioner;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_in = 1'b0;
  logic inhibit_req = 1'b0;
  logic hsync_out, hsync_strobe, polarity, vsync, pll_inhibit;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int strobe_cnt = 0;
  int hs_cnt = 0;
  int last_strobe_cyc = 0;
  int line_start = 0;
  bit vs_seen = 1'b0;

  localparam int LINE = 200;

  always #2 clk = ~clk;

  sync_conditioner i_sync_conditioner (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .inhibit_req(inhibit_req),
    .hsync_out(hsync_out), .hsync_strobe(hsync_strobe), .polarity(polarity),
    .vsync(vsync), .pll_inhibit(pll_inhibit)
  );

  always @(posedge clk) begin
    #1;
    cyc++;
    if (hsync_strobe) begin
      strobe_cnt++;
      last_strobe_cyc = cyc;
    end
    if (hsync_out) hs_cnt++;
    if (vsync) vs_seen = 1'b1;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_counts();
    strobe_cnt = 0;
    hs_cnt = 0;
    vs_seen = 1'b0;
  endtask

  task automatic send_line(input int width, input bit neg, input bit eq);
    for (int i = 0; i < LINE; i++) begin
      bit act;
      @(negedge clk);
      if (i == 0) line_start = cyc;
      act = (i < width) || (eq && i >= LINE/2 && i < LINE/2 + width);
      sync_in = neg ? !act : act;
    end
  endtask

  task automatic send_lines(input int n, input int width, input bit neg, input bit eq);
    for (int k = 0; k < n; k++) send_line(width, neg, eq);
  endtask

  task automatic t_reset();
    repeat (5) @(negedge clk);
    check("R8", "hsync_out in reset", int'(hsync_out), 0);
    check("R8", "strobe in reset", int'(hsync_strobe), 0);
    check("R8", "vsync in reset", int'(vsync), 0);
    check("R8", "polarity in reset", int'(polarity), 1);
    check("R7", "pll_inhibit idle", int'(pll_inhibit), 0);
    inhibit_req = 1'b1;
    #1;
    check("R7", "pll_inhibit forced in reset", int'(pll_inhibit), 1);
    inhibit_req = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_positive();
    send_lines(8, 20, 1'b0, 1'b0);
    clear_counts();
    send_lines(4, 20, 1'b0, 1'b0);
    check("R2", "strobes per 4 lines", strobe_cnt, 4);
    check("R2", "edge to strobe latency", last_strobe_cyc - line_start, 2);
    check("R3", "hsync_out high cycles", hs_cnt, 80);
    check("R1", "polarity positive", int'(polarity), 1);
    check("R6", "no vsync on normal lines", int'(vs_seen), 0);
  endtask

  task automatic t_narrow();
    clear_counts();
    send_lines(4, 1, 1'b0, 1'b0);
    check("R4", "one-sample pulses accepted", strobe_cnt, 4);
    check("R4", "one-sample output width", hs_cnt, 4);
  endtask

  task automatic t_equalizing();
    send_lines(2, 20, 1'b0, 1'b0);
    clear_counts();
    send_lines(4, 8, 1'b0, 1'b1);
    check("R5", "strobes with equalizing", strobe_cnt, 4);
    check("R5", "output high with equalizing", hs_cnt, 32);
  endtask

  task automatic t_hysteresis();
    send_lines(3, 20, 1'b0, 1'b0);
    clear_counts();
    send_line(20, 1'b0, 1'b0);
    send_line(70, 1'b0, 1'b0);
    send_lines(3, 20, 1'b0, 1'b0);
    check("R6", "single wide line ignored", int'(vs_seen), 0);
    check("R5", "strobes through wide line", strobe_cnt, 5);
  endtask

  task automatic t_vertical();
    clear_counts();
    send_lines(3, 70, 1'b0, 1'b0);
    check("R6", "vsync after wide lines", int'(vsync), 1);
    check("R7", "pll_inhibit during vsync", int'(pll_inhibit), 1);
    check("R5", "strobes in vertical", strobe_cnt, 3);
    send_lines(2, 20, 1'b0, 1'b0);
    check("R6", "vsync held after one normal eval", int'(vsync), 1);
    send_line(20, 1'b0, 1'b0);
    check("R6", "vsync cleared after two normal", int'(vsync), 0);
    check("R7", "pll_inhibit released", int'(pll_inhibit), 0);
  endtask

  task automatic t_inhibit();
    inhibit_req = 1'b1;
    send_lines(2, 20, 1'b0, 1'b0);
    check("R7", "pll_inhibit forced", int'(pll_inhibit), 1);
    check("R7", "vsync unaffected by request", int'(vsync), 0);
    inhibit_req = 1'b0;
    #1;
    check("R7", "pll_inhibit drops with request", int'(pll_inhibit), 0);
  endtask

  task automatic t_negative();
    send_lines(3, 20, 1'b1, 1'b0);
    check("R1", "polarity held after one window", int'(polarity), 1);
    send_lines(9, 20, 1'b1, 1'b0);
    check("R1", "polarity flipped to negative", int'(polarity), 0);
    clear_counts();
    send_lines(4, 20, 1'b1, 1'b0);
    check("R2", "strobes negative input", strobe_cnt, 4);
    check("R2", "latency negative input", last_strobe_cyc - line_start, 2);
    check("R3", "output width negative input", hs_cnt, 80);
    check("R6", "no vsync negative input", int'(vs_seen), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_positive();
    t_narrow();
    t_equalizing();
    t_hysteresis();
    t_vertical();
    t_inhibit();
    t_negative();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule